// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block turns an externally supplied timer count into two reference waveforms. A counter elsewhere in the chip presents its value, its direction and a valid strobe each clock. The block compares that value against one compare register per channel. Each channel's 4-bit mode decides how the comparison shapes its reference: hold the level, set, clear or toggle on equality, force a level, pulse-width modulate, or produce a one-pulse level that a trigger input ends. Next to the two references sit two combined outputs. In the combined and asymmetric modes these merge both channels' references. In every other mode each combined output repeats its own channel's reference.

Software reaches the block through a small register port with write-enable, address and data lines and a combinational readback. One 32-bit control word holds both channels' settings. Two compare registers follow it. Each compare register has a shadow stage. When a channel's preload bit is set, a write lands only in the shadow, and the shadow moves into the active compare value on the update strobe.

Top module: `oc_dual_unit`

## Requirements
- R1: After reset both references, both combined outputs, the control word and both active compare values are 0, and readback of addresses 0, 1 and 2 returns 0.
- R2: Address 0 is the control word, address 1 the compare register of channel 1, address 2 that of channel 2. In the control word, channel 1 owns bits 7:0: bits 1:0 direction select (0 = output), bit 2 fast enable, bit 3 preload enable, bits 6:4 mode bits 2:0, bit 7 clear enable. Its mode bit 3 is bit 16. Channel 2 uses bits 15:8 in the same layout, with its mode bit 3 at bit 24. All other bits are reserved: writes to them are dropped and they read as 0. Compare readback returns the last written value in the low CNT_W bits, zero-extended, and address 3 reads 0.
- R3: Modes 0, 10 and 11 hold the reference at its present level. A channel whose direction select is nonzero also holds its reference, whatever its mode.
- R4: While the valid strobe is high and the count equals the active compare value, mode 1 sets the reference to 1, mode 2 clears it to 0 and mode 3 inverts it. Without equality the reference is held.
- R5: Mode 4 drives the reference to 0 and mode 5 drives it to 1 on every clock, with or without the valid strobe.
- R6: Mode 6, counting up: the reference is 1 when count < compare and 0 otherwise. Mode 6, counting down: the reference is 0 when count > compare and 1 otherwise. Mode 7 gives the inverse of mode 6.
- R7: With the channel's preload bit 0, a compare write takes effect from the clock edge that accepts it.
- R8: With the channel's preload bit 1, a compare write goes only to the shadow. The shadow is copied into the active compare value on each clock in which the update strobe is high. Readback shows the shadow.
- R9: A trigger flag is set by the trigger input and cleared by the update strobe; the trigger wins when both are high. In mode 8, in each valid clock, the reference becomes 1 only when counting up and neither the flag nor the trigger input is set; otherwise it becomes 0. Mode 9 gives the inverse.
- R10: Modes 12 and 13 shape the reference like modes 6 and 7. The channel's combined output is the OR of both references in mode 12 and the AND of both in mode 13.
- R11: Modes 14 and 15 shape the reference like modes 6 and 7. The channel's combined output follows channel 1's reference while counting up and channel 2's reference while counting down. In all other modes a combined output equals its own channel's reference.
- R12: References are registered. A count-driven mode (1-3, 6-9, 12-15) changes the reference only on a clock edge at which the valid strobe is high, and the new level is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_valid | input | 1 | Count value is valid this clock |
| cnt_value | input | CNT_W | Counter value from the external counter |
| cnt_down | input | 1 | 1 while the counter counts down |
| upd_evt | input | 1 | Update strobe; moves shadow compare values and clears the trigger flag |
| trig_in | input | 1 | Trigger input used by the one-pulse modes |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address for write and readback |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register readback, combinational from reg_addr |
| ref_o | output | 2 | Reference outputs, bit 0 channel 1, bit 1 channel 2 |
| comb_o | output | 2 | Combined outputs, bit 0 channel 1, bit 1 channel 2 |

## Verification
The main stimulus walks all 256 count values upward and then downward. This is done for all sixteen mode codes on channel 1, with channel 2 in the partner code of the pair. It is repeated with compare values at 0, in the middle and at full scale. The full-scale and zero compare values separate strict from non-strict comparison in each direction. A trigger pulse in the middle of each sweep and an update strobe at its end separate the one-pulse flag's set and clear. Running the sweep in both directions tells the up and down branches of the PWM, combined and asymmetric selections apart. Targeted sequences add four further cases: valid-low clocks with a moving count, a nonzero direction select, a compare write with preload off and with preload on, and writes of all ones to reserved control bits.

// File: rtl/oc_pkg.sv
package oc_pkg;

   localparam int OC_NCH       = 2;
   localparam int OC_CH_STRIDE = 8;
   localparam int OC_PRE_BIT   = 3;
   localparam int OC_MODE_LSB  = 4;
   localparam int OC_EXT_BASE  = 16;
   localparam int OC_ADDR_CTRL = 0;
   localparam int OC_ADDR_CMP0 = 1;
   localparam logic [31:0] OC_CTRL_MASK = 32'h0101_FFFF;

   typedef enum logic [3:0] {
      OCM_FROZEN  = 4'd0,
      OCM_SET     = 4'd1,
      OCM_CLR     = 4'd2,
      OCM_TOG     = 4'd3,
      OCM_LOW     = 4'd4,
      OCM_HIGH    = 4'd5,
      OCM_PWM_A   = 4'd6,
      OCM_PWM_B   = 4'd7,
      OCM_OPM_A   = 4'd8,
      OCM_OPM_B   = 4'd9,
      OCM_RSV_A   = 4'd10,
      OCM_RSV_B   = 4'd11,
      OCM_CMB_OR  = 4'd12,
      OCM_CMB_AND = 4'd13,
      OCM_ASY_A   = 4'd14,
      OCM_ASY_B   = 4'd15
   } oc_mode_e;

   function automatic oc_mode_e oc_mode_of(input logic [31:0] w, input int ch);
      logic [3:0] m;
      m[2:0] = w[ch*OC_CH_STRIDE + OC_MODE_LSB +: 3];
      m[3]   = w[OC_EXT_BASE + ch*OC_CH_STRIDE];
      return oc_mode_e'(m);
   endfunction

   function automatic logic [1:0] oc_sel_of(input logic [31:0] w, input int ch);
      return w[ch*OC_CH_STRIDE +: 2];
   endfunction

endpackage

// File: rtl/oc_ctrl_regs.sv
module oc_ctrl_regs
   import oc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic                           upd_evt,
   output logic [DATA_W-1:0]              ctrl_q,
   output logic [OC_NCH-1:0][CNT_W-1:0]   cmp_act,
   output logic [DATA_W-1:0]              rdata
);

   localparam logic [DATA_W-1:0] WMASK = DATA_W'(OC_CTRL_MASK);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OC_ADDR_CTRL);

   logic [OC_NCH-1:0][CNT_W-1:0] cmp_sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && addr == CTRL_ADDR) begin
         ctrl_q <= wdata & WMASK;
      end
   end

   for (genvar g = 0; g < OC_NCH; g++) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(OC_ADDR_CMP0 + g);
      logic             wr_hit;
      logic             pre_on;
      logic [CNT_W-1:0] sh_q;
      logic [CNT_W-1:0] act_q;

      assign wr_hit = wr_en && (addr == MY_ADDR);
      assign pre_on = ctrl_q[g*OC_CH_STRIDE + OC_PRE_BIT];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_q  <= '0;
            act_q <= '0;
         end else begin
            if (wr_hit) begin
               sh_q <= wdata[CNT_W-1:0];
            end
            if (wr_hit && !pre_on) begin
               act_q <= wdata[CNT_W-1:0];
            end else if (pre_on && upd_evt) begin
               act_q <= sh_q;
            end
         end
      end

      assign cmp_sh[g]  = sh_q;
      assign cmp_act[g] = act_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == CTRL_ADDR) begin
         rdata = ctrl_q;
      end
      for (int i = 0; i < OC_NCH; i++) begin
         if (addr == ADDR_W'(OC_ADDR_CMP0 + i)) begin
            rdata[CNT_W-1:0] = cmp_sh[i];
         end
      end
   end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import oc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  oc_mode_e         mode,
   input  logic [1:0]       dsel,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_valid,
   input  logic             cnt_down,
   input  logic             trig_seen,
   output logic             ref_q
);

   logic hit;
   logic below;
   logic above;
   logic pwm_lvl;
   logic ref_d;

   assign hit     = (cnt == cmp);
   assign below   = (cnt < cmp);
   assign above   = (cnt > cmp);
   assign pwm_lvl = cnt_down ? !above : below;

   always_comb begin
      ref_d = ref_q;
      if (dsel == 2'b00) begin
         if (mode == OCM_LOW) begin
            ref_d = 1'b0;
         end else if (mode == OCM_HIGH) begin
            ref_d = 1'b1;
         end else if (cnt_valid) begin
            case (mode)
               OCM_SET:                          if (hit) ref_d = 1'b1;
               OCM_CLR:                          if (hit) ref_d = 1'b0;
               OCM_TOG:                          if (hit) ref_d = !ref_q;
               OCM_PWM_A, OCM_CMB_OR, OCM_ASY_A: ref_d = pwm_lvl;
               OCM_PWM_B, OCM_CMB_AND, OCM_ASY_B: ref_d = !pwm_lvl;
               OCM_OPM_A:                        ref_d = !cnt_down && !trig_seen;
               OCM_OPM_B:                        ref_d = cnt_down || trig_seen;
               default:                          ref_d = ref_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
      end else begin
         ref_q <= ref_d;
      end
   end

endmodule

// File: rtl/oc_combine.sv
module oc_combine
   import oc_pkg::*;
#(
   parameter int SELF = 0
) (
   input  oc_mode_e          mode,
   input  logic [OC_NCH-1:0] refs,
   input  logic              cnt_down,
   output logic              comb
);

   always_comb begin
      case (mode)
         OCM_CMB_OR:           comb = refs[0] | refs[1];
         OCM_CMB_AND:          comb = refs[0] & refs[1];
         OCM_ASY_A, OCM_ASY_B: comb = cnt_down ? refs[1] : refs[0];
         default:              comb = refs[SELF];
      endcase
   end

endmodule

// File: rtl/oc_dual_unit.sv
module oc_dual_unit
   import oc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_valid,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic              cnt_down,
   input  logic              upd_evt,
   input  logic              trig_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [1:0]        ref_o,
   output logic [1:0]        comb_o
);

   if (DATA_W < OC_EXT_BASE + OC_CH_STRIDE + 1) begin : g_bad_data_w
      $error("oc_dual_unit: DATA_W too small for the control word");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("oc_dual_unit: CNT_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("oc_dual_unit: ADDR_W must be at least 2");
   end

   logic [DATA_W-1:0]            ctrl_q;
   logic [OC_NCH-1:0][CNT_W-1:0] cmp_act;
   logic [OC_NCH-1:0]            ref_w;
   logic [31:0]                  ctrl_w32;
   logic                         fired_q;
   logic                         trig_seen;

   assign ctrl_w32  = ctrl_q[31:0];
   assign trig_seen = trig_in | fired_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
      end else if (trig_in) begin
         fired_q <= 1'b1;
      end else if (upd_evt) begin
         fired_q <= 1'b0;
      end
   end

   oc_ctrl_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .upd_evt (upd_evt),
      .ctrl_q  (ctrl_q),
      .cmp_act (cmp_act),
      .rdata   (reg_rdata)
   );

   for (genvar g = 0; g < OC_NCH; g++) begin : g_ch
      oc_mode_e ch_mode;
      logic     ch_comb;

      assign ch_mode = oc_mode_of(ctrl_w32, g);

      oc_channel #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode      (ch_mode),
         .dsel      (oc_sel_of(ctrl_w32, g)),
         .cmp       (cmp_act[g]),
         .cnt       (cnt_value),
         .cnt_valid (cnt_valid),
         .cnt_down  (cnt_down),
         .trig_seen (trig_seen),
         .ref_q     (ref_w[g])
      );

      oc_combine #(
         .SELF (g)
      ) u_comb (
         .mode     (ch_mode),
         .refs     (ref_w),
         .cnt_down (cnt_down),
         .comb     (ch_comb)
      );

      assign comb_o[g] = ch_comb;
   end

   assign ref_o = ref_w;

endmodule

// File: rtl/oc_dual_checker.sv
module oc_dual_checker #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_valid,
   input logic              upd_evt,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [1:0]        ref_o,
   input logic [1:0]        comb_o,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [CNT_W-1:0]  cmp_act0
);

   localparam logic [DATA_W-1:0] RSV_MASK = ~DATA_W'(32'h0101_FFFF);

   AST_FORCE_LOW_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[1:0] == 2'b00 && !ctrl_q[16] && ctrl_q[6:4] == 3'd4) |=> !ref_o[0]); // R5

   AST_FORCE_HIGH_CH2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[9:8] == 2'b00 && !ctrl_q[24] && ctrl_q[14:12] == 3'd5) |=> ref_o[1]); // R5

   AST_FROZEN_HOLD_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[16] && ctrl_q[6:4] == 3'd0) |=> $stable(ref_o[0])); // R3

   AST_IDLE_HOLD_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_valid && !ctrl_q[16] && ctrl_q[6:4] inside {3'd1, 3'd2, 3'd3, 3'd6, 3'd7})
      |=> $stable(ref_o[0])); // R12

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == '0) |-> ((reg_rdata & RSV_MASK) == '0)); // R2

   AST_PRELOAD_HOLD_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3] && !upd_evt) |=> $stable(cmp_act0)); // R8

   AST_COMB_OR_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[16] && ctrl_q[6:4] == 3'd4) |-> (comb_o[0] == (ref_o[0] | ref_o[1]))); // R10

endmodule

bind oc_dual_unit oc_dual_checker #(
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_valid (cnt_valid),
   .upd_evt   (upd_evt),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .ref_o     (ref_o),
   .comb_o    (comb_o),
   .ctrl_q    (ctrl_q),
   .cmp_act0  (cmp_act[0])
);

// File: tb/test_oc_dual_unit.sv
module test_oc_dual_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_valid = 1'b0;
   logic [7:0]  cnt_value = '0;
   logic        cnt_down = 1'b0;
   logic        upd_evt = 1'b0;
   logic        trig_in = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  ref_o;
   logic [1:0]  comb_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string cur_tag = "";

   logic [31:0] m_ctrl = '0;
   logic [7:0]  m_sh [2];
   logic [7:0]  m_act [2];
   logic        m_ref [2];
   logic        m_fired = 1'b0;

   always #10 clk = ~clk;

   oc_dual_unit i_oc_dual_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_valid (cnt_valid),
      .cnt_value (cnt_value),
      .cnt_down  (cnt_down),
      .upd_evt   (upd_evt),
      .trig_in   (trig_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ref_o     (ref_o),
      .comb_o    (comb_o)
   );

   function automatic logic [31:0] mk(int m1, int m2, bit p1, bit p2);
      logic [31:0] w = '0;
      w[6:4]   = 3'(m1);
      w[16]    = m1[3];
      w[14:12] = 3'(m2);
      w[24]    = m2[3];
      w[3]     = p1;
      w[11]    = p2;
      return w;
   endfunction

   function automatic int mode_of(int ch);
      return {m_ctrl[16 + 8*ch], m_ctrl[8*ch + 4 +: 3]};
   endfunction

   function automatic string req_of(int m);
      if (cur_tag != "") return cur_tag;
      case (m)
         1, 2, 3:   return "R4";
         4, 5:      return "R5";
         6, 7:      return "R6";
         8, 9:      return "R9";
         12, 13:    return "R10";
         14, 15:    return "R11";
         default:   return "R3";
      endcase
   endfunction

   function automatic logic ref_next(int ch, logic v, logic [7:0] c, logic d, logic t);
      int   m  = mode_of(ch);
      logic r  = m_ref[ch];
      logic pw = d ? !(c > m_act[ch]) : (c < m_act[ch]);
      logic ts = t | m_fired;
      if (m_ctrl[8*ch +: 2] != 2'b00) return r;
      if (m == 4) return 1'b0;
      if (m == 5) return 1'b1;
      if (!v) return r;
      case (m)
         1:           return (c == m_act[ch]) ? 1'b1 : r;
         2:           return (c == m_act[ch]) ? 1'b0 : r;
         3:           return (c == m_act[ch]) ? !r : r;
         6, 12, 14:   return pw;
         7, 13, 15:   return !pw;
         8:           return !d && !ts;
         9:           return d || ts;
         default:     return r;
      endcase
   endfunction

   function automatic logic comb_exp(int ch, logic d);
      case (mode_of(ch))
         12:      return m_ref[0] | m_ref[1];
         13:      return m_ref[0] & m_ref[1];
         14, 15:  return d ? m_ref[1] : m_ref[0];
         default: return m_ref[ch];
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // One clock: drive at the falling edge, model the next state, check after the next falling edge.
   task automatic cyc(logic w, logic [1:0] a, logic [31:0] wd,
                      logic v, logic [7:0] c, logic d, logic t, logic u);
      logic        nr [2];
      logic [7:0]  na [2];
      logic [7:0]  ns [2];
      logic [31:0] nc;
      reg_wr = w; reg_addr = a; reg_wdata = wd;
      cnt_valid = v; cnt_value = c; cnt_down = d; trig_in = t; upd_evt = u;
      for (int ch = 0; ch < 2; ch++) begin
         nr[ch] = ref_next(ch, v, c, d, t);
         ns[ch] = m_sh[ch];
         na[ch] = m_act[ch];
         if (w && a == 2'(ch + 1)) begin
            ns[ch] = wd[7:0];
            if (!m_ctrl[8*ch + 3]) na[ch] = wd[7:0];
         end
         if (!(w && a == 2'(ch + 1) && !m_ctrl[8*ch + 3]) && m_ctrl[8*ch + 3] && u)
            na[ch] = m_sh[ch];
      end
      nc = (w && a == 2'd0) ? (wd & 32'h0101_FFFF) : m_ctrl;
      @(posedge clk);
      @(negedge clk);
      m_fired = t ? 1'b1 : (u ? 1'b0 : m_fired);
      m_ctrl = nc;
      for (int ch = 0; ch < 2; ch++) begin
         m_ref[ch] = nr[ch];
         m_sh[ch]  = ns[ch];
         m_act[ch] = na[ch];
      end
      reg_wr = 1'b0;
      for (int ch = 0; ch < 2; ch++) begin
         chk(req_of(mode_of(ch)), $sformatf("ref ch%0d", ch + 1), 32'(ref_o[ch]), 32'(m_ref[ch]));
         chk(req_of(mode_of(ch)), $sformatf("comb ch%0d", ch + 1), 32'(comb_o[ch]), 32'(comb_exp(ch, d)));
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] wd);
      cyc(1'b1, a, wd, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, $sformatf("readback addr %0d", a), reg_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int ch = 0; ch < 2; ch++) begin
         m_sh[ch] = '0; m_act[ch] = '0; m_ref[ch] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1", "ref after reset", 32'(ref_o), 32'd0);
      chk("R1", "comb after reset", 32'(comb_o), 32'd0);
      rd_chk("R1", 2'd0, 32'd0);
      rd_chk("R1", 2'd1, 32'd0);
      rd_chk("R1", 2'd2, 32'd0);

      // R2: register map, reserved bits, compare readback
      cur_tag = "R2";
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk("R2", 2'd0, 32'h0101_FFFF);
      wr(2'd1, 32'h1234_ABCD);
      rd_chk("R2", 2'd1, 32'h0000_00CD);
      wr(2'd2, 32'h0000_0077);
      rd_chk("R2", 2'd2, 32'h0000_0077);
      rd_chk("R2", 2'd3, 32'h0000_0000);
      wr(2'd0, 32'h0000_0000);
      rd_chk("R2", 2'd0, 32'h0000_0000);

      // R3: nonzero direction select holds a PWM channel
      cur_tag = "R3";
      wr(2'd1, 32'd128);
      wr(2'd0, mk(5, 5, 0, 0));
      wr(2'd0, mk(6, 6, 0, 0) | 32'h0000_0001);
      for (int c = 0; c < 256; c += 17) cyc(1'b0, 2'd0, '0, 1'b1, 8'(c), 1'b0, 1'b0, 1'b0);

      // R12: valid low keeps count-driven modes still
      cur_tag = "R12";
      wr(2'd0, mk(6, 7, 0, 0));
      cyc(1'b0, 2'd0, '0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0);
      for (int c = 0; c < 256; c += 13) cyc(1'b0, 2'd0, '0, 1'b0, 8'(c), 1'b0, 1'b0, 1'b0);

      // R7: preload off, write effective at once
      cur_tag = "R7";
      wr(2'd1, 32'd50);
      cyc(1'b0, 2'd0, '0, 1'b1, 8'd49, 1'b0, 1'b0, 1'b0);
      chk("R7", "ref below new compare", 32'(ref_o[0]), 32'd1);
      cyc(1'b0, 2'd0, '0, 1'b1, 8'd50, 1'b0, 1'b0, 1'b0);
      chk("R7", "ref at new compare", 32'(ref_o[0]), 32'd0);

      // R8: preload on, write waits for the update strobe
      cur_tag = "R8";
      wr(2'd0, mk(6, 7, 1, 1));
      wr(2'd1, 32'd200);
      rd_chk("R8", 2'd1, 32'd200);
      cyc(1'b0, 2'd0, '0, 1'b1, 8'd100, 1'b0, 1'b0, 1'b0);
      chk("R8", "old compare still active", 32'(ref_o[0]), 32'd0);
      cyc(1'b0, 2'd0, '0, 1'b1, 8'd100, 1'b0, 1'b0, 1'b1);
      chk("R8", "compare in same clock as update", 32'(ref_o[0]), 32'd0);
      cyc(1'b0, 2'd0, '0, 1'b1, 8'd100, 1'b0, 1'b0, 1'b0);
      chk("R8", "new compare after update", 32'(ref_o[0]), 32'd1);
      cur_tag = "";

      // Sweep of every mode pair, three compare values, up then down
      for (int m = 0; m < 16; m++) begin
         wr(2'd0, mk(m, m ^ 1, 0, 0));
         for (int k = 0; k < 3; k++) begin
            int cv = (k == 0) ? 0 : ((k == 1) ? 90 : 255);
            wr(2'd1, 32'(cv));
            wr(2'd2, 32'(255 - cv));
            for (int c = 0; c < 256; c++)
               cyc(1'b0, 2'd0, '0, 1'b1, 8'(c), 1'b0, (c == 100), (c == 255));
            for (int c = 255; c >= 0; c--)
               cyc(1'b0, 2'd0, '0, 1'b1, 8'(c), 1'b1, (c == 60), (c == 0));
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule